// File: doc/BRIEF.md
# Keyed-Enable Watchdog Timer

This block is a watchdog that runs on a slow internal clock. Software controls it through one 8-bit control register. The upper five bits of that register hold an enable key and the lower three bits choose the timeout length. Only two key values are legal, and they are bit complements of each other. Any other key is treated as corruption: after a short delay the block raises a key-fault reset. What a legal key means depends on a static mode input. In always-on mode both legal keys keep the watchdog counting. In software mode one key stops the counter and the other starts it.

While the watchdog runs, a counter climbs from zero. When the counter reaches the selected power-of-two ratio, the block raises a timeout reset for one clock cycle and then starts the count again. Software keeps the counter from expiring by pulsing a clear strobe or by writing the control register; either one returns the counter to zero. Both kinds of reset set a sticky cause flag. Only a power-on reset or an explicit software write of 0 clears that flag. The input `rst_n` is the power-on reset. The block does not include the oscillator or the rest of the reset controller.

Top module: `wdt_keyed`

## Requirements
- R1: After power-on reset, `ctrl_q` reads 8'h53 (key 01010, select 011), and `tmo_rst_o`, `key_rst_o` and `cause_flag_o` are 0.
- R2: A write (`wr_en`=1) loads `wr_data` into `ctrl_q` at that clock edge. Key = bits 7:3, select = bits 2:0.
- R3: Select values 0..7 give ratios 2^8, 2^9, 2^10, 2^11, 2^12, 2^14, 2^16 and 2^18. While running, `tmo_rst_o` is high for exactly one cycle, sampled after the ratio-th edge that follows a restart. The count then starts again from zero.
- R4: With `cfg_always_on`=1, key 10101 and key 01010 both keep the counter running.
- R5: With `cfg_always_on`=0, key 10101 stops the counter, so no timeout occurs, and key 01010 runs it.
- R6: A key other than 10101 or 01010 raises `key_rst_o` after the second clock edge that follows the write which stored it. `key_rst_o` then stays high while that key remains in the register. Storing a legal key at or before that second edge prevents the fault, and storing a legal key later drops `key_rst_o` at once.
- R7: `cause_flag_o` is set at the edge after any cycle in which `tmo_rst_o` or `key_rst_o` is high.
- R8: `cause_flag_o` is cleared by `flag_wr_en`=1 with `flag_wr_data`=0. A write of 1 has no effect. A set condition in the same cycle wins over a clear.
- R9: A pulse on `clr_i` restarts the count from zero, so the next timeout comes a full ratio after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow watchdog clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| cfg_always_on | input | 1 | Static mode: 1 = always-on, 0 = software-controlled |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write value |
| clr_i | input | 1 | Counter restart strobe |
| flag_wr_en | input | 1 | Cause flag write strobe |
| flag_wr_data | input | 1 | Cause flag write value (only 0 acts) |
| ctrl_q | output | 8 | Control register readback |
| tmo_rst_o | output | 1 | One-cycle timeout reset |
| key_rst_o | output | 1 | Key-fault reset, held while the key is illegal |
| cause_flag_o | output | 1 | Sticky reset-cause flag |

## Verification
The assertions take three things for granted about the inputs. First, `cfg_always_on` is steady between power-on resets. Second, every strobe is sampled on a clock edge. Third, writes to the control register and the flag are single-cycle pulses. The stimulus meets these conditions in three ways. It changes the mode input only while reset is held. It drives every strobe for exactly one cycle, starting at a falling edge. It never writes the flag while a reset condition is active, except where it deliberately tests the rule that setting wins over clearing.

// File: rtl/wdt_key_pkg.sv
// Shared constants and helpers for the keyed watchdog.
// Assumes an 8-bit control word split into a 5-bit key and a 3-bit select.
package wdt_key_pkg;
    localparam int KEY_W  = 5;
    localparam int SEL_W  = 3;
    localparam int CTRL_W = KEY_W + SEL_W;
    localparam int MIN_EXP = 8;

    localparam logic [KEY_W-1:0]  KEY_RUN  = 5'b01010;
    localparam logic [KEY_W-1:0]  KEY_STOP = 5'b10101;
    localparam logic [CTRL_W-1:0] CTRL_POR = {KEY_RUN, 3'b011};

    // True when the key is one of the two legal patterns.
    function automatic logic key_legal(input logic [KEY_W-1:0] k);
        return (k == KEY_RUN) || (k == KEY_STOP);
    endfunction

    // Maps a select code to the power-of-two exponent of the ratio.
    function automatic int unsigned sel_to_exp(input logic [SEL_W-1:0] s);
        int unsigned e;
        if (s < 3'd4) e = MIN_EXP + int'(s);
        else          e = MIN_EXP + 4 + 2 * (int'(s) - 4);
        return e;
    endfunction
endpackage

// File: rtl/wdt_ctrl_reg.sv
// Holds the control word written by software.
// Assumes wr_en is a single-cycle strobe sampled on the slow clock.
module wdt_ctrl_reg
    import wdt_key_pkg::*;
#(
    parameter int W = CTRL_W,
    parameter logic [W-1:0] POR_VAL = CTRL_POR
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] ctrl_q
);
    // Load the word on a write, return to the power-on value on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     ctrl_q <= POR_VAL;
        else if (wr_en) ctrl_q <= wr_data;
    end
endmodule

// File: rtl/wdt_key_guard.sv
// Watches the key field and raises a fault after DLY edges of an illegal key.
// The output is gated by the current key, so a legal rewrite drops it at once.
module wdt_key_guard
    import wdt_key_pkg::*;
#(
    parameter int DLY = 2,
    localparam int DW = $clog2(DLY + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [KEY_W-1:0] key,
    output logic             fault_o
);
    logic          bad;
    logic [DW-1:0] dly_q;
    logic          hit_q;

    // Decode whether the stored key is corrupt.
    always_comb bad = !key_legal(key);

    // Count edges spent with a bad key and latch the fault after DLY of them.
    always_ff @(posedge clk) begin
        if (!rst_n || !bad) begin
            dly_q <= '0;
            hit_q <= 1'b0;
        end else if (dly_q == DW'(DLY - 1)) begin
            hit_q <= 1'b1;
        end else begin
            dly_q <= dly_q + 1'b1;
        end
    end

    // Present the fault only while the key is still bad.
    always_comb fault_o = hit_q && bad;
endmodule

// File: rtl/wdt_tmo_counter.sv
// Free-running timeout counter with selectable power-of-two ratio.
// Assumes the ratio exponent never exceeds CNT_W.
module wdt_tmo_counter
    import wdt_key_pkg::*;
#(
    parameter int CNT_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [SEL_W-1:0] sel,
    output logic             tmo_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   ratio;
    logic             at_end;

    // Derive the ratio and detect the final count.
    always_comb begin
        ratio  = {{CNT_W{1'b0}}, 1'b1} << sel_to_exp(sel);
        at_end = ({1'b0, cnt_q} == ratio - 1'b1);
    end

    // Advance the count, wrapping with a one-cycle timeout pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt_q <= '0;
            tmo_o <= 1'b0;
        end else if (!run) begin
            tmo_o <= 1'b0;
        end else if (at_end) begin
            cnt_q <= '0;
            tmo_o <= 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
            tmo_o <= 1'b0;
        end
    end
endmodule

// File: rtl/wdt_cause_flag.sv
// Sticky reset-cause flag: set by either reset source, cleared by writing 0.
// A set in the same cycle as a clear takes priority.
module wdt_cause_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic wr_en,
    input  logic wr_data,
    output logic flag_o
);
    // Hold the flag until software clears it or power-on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                 flag_o <= 1'b0;
        else if (set_i)             flag_o <= 1'b1;
        else if (wr_en && !wr_data) flag_o <= 1'b0;
    end
endmodule

// File: rtl/wdt_keyed.sv
// Keyed-enable watchdog top. It combines the control register, the key guard,
// the timeout counter and the cause flag.
// Assumes cfg_always_on is static between power-on resets.
module wdt_keyed
    import wdt_key_pkg::*;
#(
    parameter int CNT_W   = 18,
    parameter int KEY_DLY = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_always_on,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              clr_i,
    input  logic              flag_wr_en,
    input  logic              flag_wr_data,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic              tmo_rst_o,
    output logic              key_rst_o,
    output logic              cause_flag_o
);
    logic [KEY_W-1:0] key;
    logic [SEL_W-1:0] sel;
    logic             run;

    wdt_ctrl_reg u_reg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
        .wr_data(wr_data), .ctrl_q(ctrl_q)
    );

    // Split the control word and decide whether counting is allowed.
    always_comb begin
        key = ctrl_q[CTRL_W-1:SEL_W];
        sel = ctrl_q[SEL_W-1:0];
        run = cfg_always_on || (key != KEY_STOP);
    end

    wdt_key_guard #(.DLY(KEY_DLY)) u_guard (
        .clk(clk), .rst_n(rst_n), .key(key), .fault_o(key_rst_o)
    );

    wdt_tmo_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(run), .restart(clr_i || wr_en),
        .sel(sel), .tmo_o(tmo_rst_o)
    );

    wdt_cause_flag u_flag (
        .clk(clk), .rst_n(rst_n), .set_i(tmo_rst_o || key_rst_o),
        .wr_en(flag_wr_en), .wr_data(flag_wr_data), .flag_o(cause_flag_o)
    );
endmodule

// File: rtl/wdt_keyed_chk.sv
// Assertion checker for the keyed watchdog, attached by bind.
module wdt_keyed_chk
    import wdt_key_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_always_on,
    input logic              wr_en,
    input logic [CTRL_W-1:0] wr_data,
    input logic              clr_i,
    input logic              flag_wr_en,
    input logic              flag_wr_data,
    input logic [CTRL_W-1:0] ctrl_q,
    input logic              tmo_rst_o,
    input logic              key_rst_o,
    input logic              cause_flag_o
);
    // R2
    ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ctrl_q == $past(wr_data));
    // R3
    tmo_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_rst_o |=> !tmo_rst_o);
    // R9
    restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i || wr_en) |=> !tmo_rst_o);
    // R5
    stopped_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_always_on && ctrl_q[CTRL_W-1:SEL_W] == KEY_STOP && !wr_en) |=> !tmo_rst_o);
    // R6
    fault_needs_bad_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_rst_o |-> !key_legal(ctrl_q[CTRL_W-1:SEL_W]));
    // R6
    legal_write_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && key_legal(wr_data[CTRL_W-1:SEL_W])) |=> !key_rst_o);
    // R7
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_rst_o || key_rst_o) |=> cause_flag_o);
    // R8
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_flag_o && !(flag_wr_en && !flag_wr_data)) |=> cause_flag_o);
endmodule

bind wdt_keyed wdt_keyed_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_always_on(cfg_always_on),
    .wr_en(wr_en), .wr_data(wr_data), .clr_i(clr_i),
    .flag_wr_en(flag_wr_en), .flag_wr_data(flag_wr_data),
    .ctrl_q(ctrl_q), .tmo_rst_o(tmo_rst_o), .key_rst_o(key_rst_o),
    .cause_flag_o(cause_flag_o)
);

// File: tb/wdt_keyed_bench.sv
module wdt_keyed_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_always_on = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       clr_i = 1'b0;
    logic       flag_wr_en = 1'b0;
    logic       flag_wr_data = 1'b0;
    logic [7:0] ctrl_q;
    logic       tmo_rst_o, key_rst_o, cause_flag_o;

    int checks = 0;
    int errors = 0;

    localparam int NONE_WIN = 5000;
    // {mode, control byte, expected ratio (0 = no timeout within NONE_WIN)}
    localparam logic [24:0] VEC [0:7] = '{
        {1'b1, 8'b01010_000, 16'd256},
        {1'b0, 8'b01010_001, 16'd512},
        {1'b1, 8'b10101_010, 16'd1024},
        {1'b0, 8'b01010_011, 16'd2048},
        {1'b0, 8'b01010_100, 16'd4096},
        {1'b0, 8'b01010_101, 16'd16384},
        {1'b0, 8'b10101_000, 16'd0},
        {1'b1, 8'b10101_000, 16'd256}
    };

    always #10 clk = ~clk;

    wdt_keyed u_wdt_keyed (
        .clk(clk), .rst_n(rst_n), .cfg_always_on(cfg_always_on),
        .wr_en(wr_en), .wr_data(wr_data), .clr_i(clr_i),
        .flag_wr_en(flag_wr_en), .flag_wr_data(flag_wr_data),
        .ctrl_q(ctrl_q), .tmo_rst_o(tmo_rst_o), .key_rst_o(key_rst_o),
        .cause_flag_o(cause_flag_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic mode);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_always_on = mode;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic write_ctrl(input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic write_flag(input logic v);
        @(negedge clk);
        flag_wr_en = 1'b1;
        flag_wr_data = v;
        @(negedge clk);
        flag_wr_en = 1'b0;
    endtask

    // Counts edges until tmo_rst_o is seen high, up to lim.
    task automatic count_to_tmo(input int lim, output int n);
        n = 0;
        while (n < lim) begin
            @(posedge clk);
            #1;
            n++;
            if (tmo_rst_o) break;
        end
        if (!tmo_rst_o) n = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        // Table walk: ratios and mode/key behaviour (R3, R4, R5)
        foreach (VEC[i]) begin
            do_reset(VEC[i][24]);
            write_ctrl(VEC[i][23:16]);
            count_to_tmo(VEC[i][15:0] == 0 ? NONE_WIN : int'(VEC[i][15:0]) + 4, n);
            check(n == int'(VEC[i][15:0]),
                  VEC[i][15:0] == 0 ? "R5 stopped" : (VEC[i][24] ? "R4/R3 ratio" : "R3 ratio"),
                  n, int'(VEC[i][15:0]));
        end

        // R1 reset state
        do_reset(1'b0);
        #1;
        check(ctrl_q == 8'h53, "R1 ctrl", ctrl_q, 8'h53);
        check(!tmo_rst_o && !key_rst_o && !cause_flag_o, "R1 outputs",
              {tmo_rst_o, key_rst_o, cause_flag_o}, 0);

        // R2 readback
        write_ctrl(8'b01010_000);
        check(ctrl_q == 8'h50, "R2 readback", ctrl_q, 8'h50);

        // R9 clear strobe restarts
        repeat (200) @(posedge clk);
        @(negedge clk); clr_i = 1'b1;
        @(negedge clk); clr_i = 1'b0;
        count_to_tmo(400, n);
        check(n == 256, "R9 clear restart", n, 256);
        @(posedge clk); #1;
        check(!tmo_rst_o, "R3 one cycle", tmo_rst_o, 0);
        check(cause_flag_o, "R7 flag on timeout", cause_flag_o, 1);
        count_to_tmo(400, n);
        check(n == 255, "R3 rewrap", n, 255);

        // R8 flag write semantics
        write_flag(1'b1);
        check(cause_flag_o, "R8 write one ignored", cause_flag_o, 1);
        write_flag(1'b0);
        check(!cause_flag_o, "R8 write zero clears", cause_flag_o, 0);

        // R6 cancel: legal key stored on the second edge
        write_ctrl(8'b11111_000);
        write_ctrl(8'b01010_000);
        n = 0;
        repeat (10) begin
            @(posedge clk); #1;
            if (key_rst_o || cause_flag_o) n++;
        end
        check(n == 0, "R6 cancelled fault", n, 0);

        // R6 fault timing, held level, and release (software mode)
        write_ctrl(8'b00000_000);
        @(posedge clk); #1;
        check(!key_rst_o, "R6 not after first edge", key_rst_o, 0);
        @(posedge clk); #1;
        check(key_rst_o, "R6 after second edge", key_rst_o, 1);
        @(posedge clk); #1;
        check(cause_flag_o, "R7 flag on key fault", cause_flag_o, 1);
        write_flag(1'b0);
        check(cause_flag_o, "R8 set wins", cause_flag_o, 1);
        repeat (4) @(posedge clk); #1;
        check(key_rst_o, "R6 held", key_rst_o, 1);
        write_ctrl(8'b10101_000);
        check(!key_rst_o, "R6 released", key_rst_o, 0);
        write_flag(1'b0);
        check(!cause_flag_o, "R8 cleared after fault", cause_flag_o, 0);

        // R6 in always-on mode
        do_reset(1'b1);
        write_ctrl(8'b00111_000);
        repeat (2) @(posedge clk); #1;
        check(key_rst_o, "R6 always-on fault", key_rst_o, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule